// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block runs transactions against a 16-bit control-register port of a PHY. The port is reached through a 20-bit control word and a status word. The control word holds a 16-bit field for address or data and four strobe lines. The status word returns an acknowledge line and 16 bits of read data. Every step of a transaction raises one strobe, waits for the acknowledge to rise, drops the strobe, and then waits for the acknowledge to fall.

A client starts a transaction with a one-cycle start pulse, an operation code and 16 bits of write data. There are three operations:
- An address transaction latches a register address in the PHY with one step.
- A write transaction takes two steps: it first captures the data, then commits it to the addressed register.
- A read transaction raises only the read strobe and latches the returned data.

When the transaction ends, the block gives a one-cycle done pulse, a sticky error flag and the read data.

Every acknowledge wait is bounded by a retry count. The acknowledge is sampled on poll ticks whose spacing is set by a prescaler input. When the retries run out, the transaction is aborted, the control word is cleared and the error flag is raised.

Top module: `phy_cr_master`

## Requirements
- R1: After reset, `phy_ctl` is all zeros, `busy`, `rsp_done` and `rsp_error` are 0, and `rsp_rdata` is 0.
- R2: An address transaction (`cmd_op` = 0) drives `phy_ctl` = `cmd_wdata` with bit 16 set, starting the cycle after the start edge. Once the acknowledge is seen high, it clears bit 16 and keeps bits [15:0] until the next transaction.
- R3: A write transaction (`cmd_op` = 1) first drives bit 17 with the data in bits [15:0]. After that step's acknowledge falls, it drives bit 18 with the data still in bits [15:0]. When that strobe is released, the whole control word becomes 0.
- R4: A read transaction (`cmd_op` = 2) drives only bit 19 (bits [15:0] are 0). It latches `phy_stat[15:0]` into `rsp_rdata` at the poll that sees `phy_stat[18]` high, then clears the control word and waits for the acknowledge to fall.
- R5: At most one of the strobe bits 19:16 of `phy_ctl` is set in any cycle.
- R6: Each acknowledge wait allows one first poll plus 100 retries. If the 101st poll still misses the expected level, the transaction ends with `rsp_done` and `rsp_error` both 1.
- R7: The acknowledge is polled once every `poll_div`+1 cycles, counted from the cycle a wait begins. With `poll_div` = 0, every cycle is a poll.
- R8: A start pulse is ignored while `busy` is 1, and a start with reserved code `cmd_op` = 3 is ignored. Neither one produces a transaction or a done pulse.
- R9: `rsp_done` is high for exactly one cycle per transaction. `rsp_error` and `rsp_rdata` hold their values until the next accepted start, which clears both.
- R10: After an abort, `phy_ctl` is 0 and the block accepts the next transaction normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle start of a transaction |
| cmd_op | input | 2 | 0 address, 1 write, 2 read, 3 reserved |
| cmd_wdata | input | 16 | Address or write data |
| poll_div | input | 8 | Poll interval minus one, in cycles |
| busy | output | 1 | Transaction in progress |
| rsp_done | output | 1 | One-cycle end-of-transaction pulse |
| rsp_error | output | 1 | Last transaction timed out |
| rsp_rdata | output | 16 | Data latched by the last read |
| phy_ctl | output | 20 | Data field [15:0]; strobes: 16 capture address, 17 capture data, 18 write, 19 read |
| phy_stat | input | 19 | Read data [15:0]; acknowledge at bit 18 |

## Verification
The bench models the PHY with an acknowledge that follows the strobes one cycle later. Each wait therefore ends at the first poll that falls two or more cycles after it began, which is ceil(2/(D+1))·(D+1) cycles for divider D. From this the bench computes when `rsp_done` is due:
- Address and read transactions end after two waits.
- A write ends after four waits.
- A wait that never succeeds costs 101 polls.

The driver records the start edge and queues the expected latency, read data and error. The monitor samples on the falling edge, counts cycles from the start edge to the done pulse, and compares the count and the values exactly. The driver also checks `phy_ctl` one cycle after the start edge and again after done.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

    localparam int DATA_W  = 16;
    localparam int CTL_W   = 20;
    localparam int STAT_W  = 19;
    localparam int ACK_POS = 18;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RAISE,
        PH_DROP
    } phase_e;

    typedef enum logic [1:0] {
        ST_CAPA,
        ST_CAPD,
        ST_COMMIT,
        ST_FETCH
    } step_e;

    typedef struct packed {
        step_e             step;
        logic [DATA_W-1:0] data;
    } xact_t;

    // Control word while a step's strobe is raised
    function automatic logic [CTL_W-1:0] raise_word(step_e s, logic [DATA_W-1:0] d);
        case (s)
            ST_CAPA:   return {4'b0001, d};
            ST_CAPD:   return {4'b0010, d};
            ST_COMMIT: return {4'b0100, d};
            default:   return {4'b1000, {DATA_W{1'b0}}};
        endcase
    endfunction

    // Control word once a step's strobe is released
    function automatic logic [CTL_W-1:0] drop_word(step_e s, logic [DATA_W-1:0] d);
        case (s)
            ST_CAPA, ST_CAPD: return {4'b0000, d};
            default:          return '0;
        endcase
    endfunction

    function automatic step_e first_step(op_e op);
        case (op)
            OP_ADDR:  return ST_CAPA;
            OP_WRITE: return ST_CAPD;
            default:  return ST_FETCH;
        endcase
    endfunction

endpackage

// File: rtl/cr_poll_pacer.sv
module cr_poll_pacer #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R7
    property pace_bound_p;
        @(posedge clk) disable iff (rst) (!tick && !restart && $stable(div)) |=> (cnt != '0);
    endproperty
    pace_bound_chk: assert property (pace_bound_p);

endmodule

// File: rtl/cr_retry_guard.sv
module cr_retry_guard #(
    parameter int MAX_RETRY = 100,
    localparam int CNT_W    = $clog2(MAX_RETRY + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    input  logic ack_ok,
    output logic expired
);
    logic [CNT_W-1:0] miss_cnt;
    logic             at_limit;

    assign at_limit = (miss_cnt == CNT_W'(MAX_RETRY));
    assign expired  = tick && !ack_ok && at_limit;

    always_ff @(posedge clk) begin
        if (rst || restart)
            miss_cnt <= '0;
        else if (tick && !ack_ok && !at_limit)
            miss_cnt <= miss_cnt + 1'b1;
    end

    // R6
    property miss_bound_p;
        @(posedge clk) disable iff (rst) miss_cnt <= CNT_W'(MAX_RETRY);
    endproperty
    miss_bound_chk: assert property (miss_bound_p);

endmodule

// File: rtl/cr_step_fsm.sv
module cr_step_fsm
    import phy_cr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              ack,
    input  logic [DATA_W-1:0] stat_data,
    input  logic              tick,
    input  logic              expired,
    output logic              busy,
    output logic              restart,
    output logic              ack_ok,
    output logic              done,
    output logic              error,
    output logic [DATA_W-1:0] rdata,
    output logic [CTL_W-1:0]  ctl
);
    phase_e phase;
    xact_t  cur;
    op_e    op_in;
    logic   op_valid;
    logic   advance;

    assign op_in    = op_e'(cmd_op);
    assign op_valid = (op_in != OP_RSVD);
    assign busy     = (phase != PH_IDLE);
    assign ack_ok   = (phase == PH_RAISE) ? ack : !ack;
    assign advance  = busy && tick && ack_ok;
    assign restart  = (!busy && cmd_start && op_valid) || advance;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cur   <= '{step: ST_CAPA, data: '0};
            ctl   <= '0;
            done  <= 1'b0;
            error <= 1'b0;
            rdata <= '0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (cmd_start && op_valid) begin
                        phase    <= PH_RAISE;
                        cur.step <= first_step(op_in);
                        cur.data <= cmd_wdata;
                        ctl      <= raise_word(first_step(op_in), cmd_wdata);
                        error    <= 1'b0;
                        rdata    <= '0;
                    end
                end
                PH_RAISE: begin
                    if (advance) begin
                        if (cur.step == ST_FETCH)
                            rdata <= stat_data;
                        ctl   <= drop_word(cur.step, cur.data);
                        phase <= PH_DROP;
                    end else if (expired) begin
                        ctl   <= '0;
                        error <= 1'b1;
                        done  <= 1'b1;
                        phase <= PH_IDLE;
                    end
                end
                PH_DROP: begin
                    if (advance) begin
                        if (cur.step == ST_CAPD) begin
                            cur.step <= ST_COMMIT;
                            ctl      <= raise_word(ST_COMMIT, cur.data);
                            phase    <= PH_RAISE;
                        end else begin
                            done  <= 1'b1;
                            phase <= PH_IDLE;
                        end
                    end else if (expired) begin
                        ctl   <= '0;
                        error <= 1'b1;
                        done  <= 1'b1;
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R5
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctl[CTL_W-1:DATA_W]));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    error_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> done);

    // R10
    abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
        error |-> (ctl == '0));

    // R2
    drop_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DROP) |-> (ctl[CTL_W-1:DATA_W] == '0));

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_start && !tick) |=> $stable(ctl));

endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
    import phy_cr_pkg::*;
#(
    parameter int PRE_W     = 8,
    parameter int MAX_RETRY = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic [15:0]       cmd_wdata,
    input  logic [PRE_W-1:0]  poll_div,
    output logic              busy,
    output logic              rsp_done,
    output logic              rsp_error,
    output logic [15:0]       rsp_rdata,
    output logic [19:0]       phy_ctl,
    input  logic [18:0]       phy_stat
);
    logic tick;
    logic restart;
    logic ack_ok;
    logic expired;
    logic unused_stat;

    assign unused_stat = ^phy_stat[ACK_POS-1:DATA_W];

    cr_poll_pacer #(.PRE_W(PRE_W)) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .div     (poll_div),
        .tick    (tick)
    );

    cr_retry_guard #(.MAX_RETRY(MAX_RETRY)) u_guard (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick),
        .ack_ok  (ack_ok),
        .expired (expired)
    );

    cr_step_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd_start (cmd_start),
        .cmd_op    (cmd_op),
        .cmd_wdata (cmd_wdata),
        .ack       (phy_stat[ACK_POS]),
        .stat_data (phy_stat[DATA_W-1:0]),
        .tick      (tick),
        .expired   (expired),
        .busy      (busy),
        .restart   (restart),
        .ack_ok    (ack_ok),
        .done      (rsp_done),
        .error     (rsp_error),
        .rdata     (rsp_rdata),
        .ctl       (phy_ctl)
    );

endmodule

// File: tb/test_phy_cr_master.sv
module test_phy_cr_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_start = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_wdata = 16'h0;
    logic [7:0]  poll_div = 8'd0;
    logic        busy, rsp_done, rsp_error;
    logic [15:0] rsp_rdata;
    logic [19:0] phy_ctl;
    logic [18:0] phy_stat;

    always #5 clk = ~clk;

    phy_cr_master i_phy_cr_master (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .poll_div(poll_div), .busy(busy),
        .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
        .phy_ctl(phy_ctl), .phy_stat(phy_stat)
    );

    // PHY model: ack follows any strobe one cycle later
    logic [15:0] mem [16];
    logic [15:0] pa, pd;
    logic [3:0]  prev_stb;
    logic        ack, fault_lo = 1'b0, fault_hi = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            ack <= 1'b0; pa <= '0; pd <= '0; prev_stb <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= '0;
        end else begin
            prev_stb <= phy_ctl[19:16];
            ack <= fault_hi | (!fault_lo & (|phy_ctl[19:16]));
            if (phy_ctl[16] && !prev_stb[0]) pa <= phy_ctl[15:0];
            if (phy_ctl[17] && !prev_stb[1]) pd <= phy_ctl[15:0];
            if (phy_ctl[18] && !prev_stb[2]) mem[pa[3:0]] <= pd;
        end
    end
    assign phy_stat = {ack, 2'b00, mem[pa[3:0]]};

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    int start_cyc = 0;

    typedef struct packed {
        logic [31:0] lat;
        logic [15:0] rd;
        logic        err;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected items as done pulses appear
    always @(negedge clk) begin
        if (!rst && rsp_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check((cyc - start_cyc) == e.lat, {t, " latency"}, 32'(cyc - start_cyc), e.lat);
                check(rsp_error == e.err, {t, " error"}, 32'(rsp_error), 32'(e.err));
                check(rsp_rdata == e.rd, {t, " rdata"}, 32'(rsp_rdata), 32'(e.rd));
            end
        end
    end

    function automatic int step_lat(input int d);
        return 2 * (((2 + d) / (d + 1)) * (d + 1));
    endfunction

    // Driver: call on a falling edge
    task automatic issue(input logic [1:0] op, input logic [15:0] wd, input int lat,
                         input logic [15:0] rd, input logic err, input string tag);
        logic [31:0] first;
        while (busy) @(negedge clk);
        cmd_op = op; cmd_wdata = wd; cmd_start = 1'b1;
        start_cyc = cyc + 1;
        exp_q.push_back('{lat: 32'(lat), rd: rd, err: err});
        tag_q.push_back(tag);
        @(negedge clk);
        cmd_start = 1'b0;
        case (op)
            2'd0:    first = 32'h10000 | 32'(wd);
            2'd1:    first = 32'h20000 | 32'(wd);
            default: first = 32'h80000;
        endcase
        check(32'(phy_ctl) == first, {tag, " first word"}, 32'(phy_ctl), first);
        check(rsp_error == 1'b0, "R9 error cleared at start", 32'(rsp_error), 32'd0);
        while (exp_q.size() != 0) @(negedge clk);
        if (!err) begin
            if (op == 2'd0)
                check(32'(phy_ctl) == 32'(wd), "R2 data kept after release", 32'(phy_ctl), 32'(wd));
            else
                check(phy_ctl == 20'h0, {tag, " word cleared after release"}, 32'(phy_ctl), 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(phy_ctl == 20'h0, "R1 ctl reset", 32'(phy_ctl), 32'd0);
        check(!busy, "R1 busy reset", 32'(busy), 32'd0);
        check(!rsp_done && !rsp_error, "R1 done/error reset", {30'd0, rsp_done, rsp_error}, 32'd0);
        check(rsp_rdata == 16'h0, "R1 rdata reset", 32'(rsp_rdata), 32'd0);

        // R2 R3 R4 with poll_div = 0
        poll_div = 8'd0;
        issue(2'd0, 16'h0003, step_lat(0), 16'h0, 1'b0, "R2 address");
        issue(2'd1, 16'hA5C3, 2 * step_lat(0), 16'h0, 1'b0, "R3 write");
        issue(2'd2, 16'h0000, step_lat(0), 16'hA5C3, 1'b0, "R4 read");
        issue(2'd0, 16'h0007, step_lat(0), 16'h0, 1'b0, "R2 address b");
        issue(2'd1, 16'h1234, 2 * step_lat(0), 16'h0, 1'b0, "R3 write b");
        issue(2'd0, 16'h0003, step_lat(0), 16'h0, 1'b0, "R2 address c");
        issue(2'd2, 16'hFFFF, step_lat(0), 16'hA5C3, 1'b0, "R4 read other register");
        // R9: rdata holds after done
        repeat (4) @(negedge clk);
        check(rsp_rdata == 16'hA5C3, "R9 rdata held", 32'(rsp_rdata), 32'hA5C3);

        // R7: slower poll intervals
        poll_div = 8'd2;
        issue(2'd0, 16'h0007, step_lat(2), 16'h0, 1'b0, "R7 address div2");
        issue(2'd1, 16'hBEEF, 2 * step_lat(2), 16'h0, 1'b0, "R7 write div2");
        poll_div = 8'd1;
        issue(2'd2, 16'h0000, step_lat(1), 16'hBEEF, 1'b0, "R7 read div1");
        poll_div = 8'd5;
        issue(2'd2, 16'h0000, step_lat(5), 16'hBEEF, 1'b0, "R7 read div5");

        // R8: start while busy is ignored
        poll_div = 8'd0;
        cmd_op = 2'd0; cmd_wdata = 16'h0009; cmd_start = 1'b1;
        start_cyc = cyc + 1;
        exp_q.push_back('{lat: 32'(step_lat(0)), rd: 16'h0, err: 1'b0});
        tag_q.push_back("R8 address under busy start");
        @(negedge clk); cmd_start = 1'b0;
        @(negedge clk); cmd_op = 2'd1; cmd_wdata = 16'hFFFF; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(!busy, "R8 no second transaction", 32'(busy), 32'd0);
        issue(2'd2, 16'h0000, step_lat(0), 16'h0000, 1'b0, "R8 register untouched");

        // R8: reserved op code
        cmd_op = 2'd3; cmd_wdata = 16'h00AA; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        check(!busy, "R8 reserved op not started", 32'(busy), 32'd0);
        check(phy_ctl == 20'h0, "R8 reserved op ctl", 32'(phy_ctl), 32'd0);
        repeat (3) @(negedge clk);

        // R6: ack never rises
        fault_lo = 1'b1;
        issue(2'd0, 16'h000C, 101, 16'h0, 1'b1, "R6 ack never rises");
        check(phy_ctl == 20'h0, "R10 ctl cleared after abort", 32'(phy_ctl), 32'd0);
        fault_lo = 1'b0;
        repeat (5) @(negedge clk);
        check(rsp_error == 1'b1, "R9 error held", 32'(rsp_error), 32'd1);

        // R6: ack never falls
        issue(2'd0, 16'h0007, step_lat(0), 16'h0, 1'b0, "R10 address after abort");
        fault_hi = 1'b1;
        issue(2'd2, 16'h0000, 102, 16'hBEEF, 1'b1, "R6 ack never falls");
        check(phy_ctl == 20'h0, "R10 ctl cleared after abort b", 32'(phy_ctl), 32'd0);
        fault_hi = 1'b0;
        repeat (2) @(negedge clk);

        // R10: normal operation resumes
        issue(2'd2, 16'h0000, step_lat(0), 16'hBEEF, 1'b0, "R10 read after abort");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule